// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block models the synchronous control path of a pipelined burst SRAM with byte-lane writes. On every rising clock edge it looks at two address strobes, three chip enables, a burst advance input and the write controls, and it classifies the cycle. The cycle is one of: idle, deselect, begin burst, continue burst, or suspend burst. Writes go into a small internal array under a per-lane mask. Reads return data one clock after the address is registered. The output is driven only while an asynchronous output enable allows it.

One strobe (`strobe_p_n`) always starts a read. It is ignored while `ce_a_n` is high. The other strobe (`strobe_c_n`) can start a read or a write, and it deselects the device when any enable is false. Between strobes, `adv_n` either steps a 2-bit burst counter or holds it. The counter steps in linear or interleaved order. Enables are looked at only on strobe cycles.

The data bus is modelled as `dq_o` plus a drive flag `dq_en`. `dq_o` reads zero whenever `dq_en` is low, which stands for high impedance.

Top module: `sbs_front`

## Requirements
- R1: After reset the device is deselected: `dq_en` is 0, and cycles with no strobe neither read nor write.
- R2: The enables count only in a strobe cycle, and they select the device only when `ce_hi`=1 and `ce_b_n`=0; otherwise a strobe deselects. Enable changes in cycles with no strobe have no effect on a running burst.
- R3: While `ce_a_n`=1, `strobe_p_n` is ignored (the cycle behaves as if no strobe were present). A low `strobe_c_n` with `ce_a_n`=1 deselects.
- R4: A burst begun by `strobe_p_n` (with `ce_a_n`=0) is a read, even when write controls are active.
- R5: `gwr_n`=0 writes all four lanes. Otherwise a write happens only when `bwe_n`=0, and only to lanes whose `lane_n` bit is 0; lane i is `wdata[8i+7:8i]`. Any other combination is a read.
- R6: Burst address bits [1:0] follow start+k mod 4 when `linear_n`=0, and start XOR k when `linear_n`=1 (k = 0,1,2,3). The fifth access returns to the start address. The upper address bits stay fixed.
- R7: With no strobe and `adv_n`=1, the current address is reused; the cycle may be a read or a write.
- R8: For a read registered at edge k, its data is on `dq_o` after edge k+1. After a write or a deselect at edge k, `dq_en` is 0 after edge k+1.
- R9: `oe_n`=1 forces `dq_en` to 0 immediately, with no clock. `oe_n`=0 enables the drive only while the output register holds read data.
- R10: A read made with `oe_n`=1 still steps the burst counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address, loaded on a begin cycle |
| wdata | input | DW | Write data, four 8-bit lanes |
| strobe_p_n | input | 1 | Read-only address strobe, active low, masked by ce_a_n |
| strobe_c_n | input | 1 | General address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_a_n | input | 1 | Chip enable, active low; also masks strobe_p_n |
| ce_hi | input | 1 | Chip enable, active high |
| ce_b_n | input | 1 | Chip enable, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_n | input | DW/8 | Per-lane write select, active low |
| linear_n | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_o | output | DW | Read data; zero when not driven |
| dq_en | output | 1 | Bus drive flag |

## Verification
Suppose the burst counter holds a wrong value, or the block believes it is active when it should be deselected. The port shows this one cycle after the next access: the wrong word appears on `dq_o`, or a drive appears where the bus should float. A lane mask that is wrong stays hidden in the array until that word is read back, so every masked write is followed by a read of the same word. A mistake in the strobe priority changes which address the next access uses. It therefore appears as data from the wrong location two edges later.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_DESEL = 3'd1,
    OP_BEGIN = 3'd2,
    OP_CONT  = 3'd3,
    OP_SUSP  = 3'd4
  } op_e;

  // low address bits of burst access number step, given the start bits
  function automatic logic [1:0] burst_slot(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       linear);
    return linear ? (start + step) : (start ^ step);
  endfunction
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             strobe_p_n,
  input  logic             strobe_c_n,
  input  logic             adv_n,
  input  logic             ce_a_n,
  input  logic             ce_hi,
  input  logic             ce_b_n,
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             active,
  output op_e              op,
  output logic             rd_now,
  output logic             wr_now,
  output logic [LANES-1:0] wr_mask
);
  logic p_take, c_take, sel_ok, wr_req, access;

  assign p_take = !strobe_p_n && !ce_a_n;
  assign c_take = !strobe_c_n;
  assign sel_ok = ce_hi && !ce_b_n;
  assign wr_req = !gwr_n || (!bwe_n && !(&lane_n));

  always_comb begin
    op = OP_IDLE;
    if (p_take)      op = sel_ok ? OP_BEGIN : OP_DESEL;
    else if (c_take) op = (sel_ok && !ce_a_n) ? OP_BEGIN : OP_DESEL;
    else if (active) op = adv_n ? OP_SUSP : OP_CONT;
  end

  assign access  = (op == OP_BEGIN) || (op == OP_CONT) || (op == OP_SUSP);
  assign wr_now  = access && !p_take && wr_req;
  assign rd_now  = access && !wr_now;
  assign wr_mask = !wr_now ? '0 : (!gwr_n ? '1 : ~lane_n);
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] addr_in,
  input  logic          linear_n,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] cur_addr,
  output logic          active
);
  logic [AW-1:2] hi_q;
  logic [1:0]    start_q, step_q, step_nx;

  assign step_nx  = step_q + 2'd1;
  assign cur_addr = {hi_q, burst_slot(start_q, step_q, !linear_n)};

  always_comb begin
    case (op)
      OP_BEGIN: eff_addr = addr_in;
      OP_CONT:  eff_addr = {hi_q, burst_slot(start_q, step_nx, !linear_n)};
      default:  eff_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      step_q  <= '0;
      active  <= 1'b0;
    end else begin
      case (op)
        OP_BEGIN: begin
          hi_q    <= addr_in[AW-1:2];
          start_q <= addr_in[1:0];
          step_q  <= '0;
          active  <= 1'b1;
        end
        OP_CONT:  step_q <= step_nx;
        OP_DESEL: active <= 1'b0;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_mask,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_mask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbs_front.sv
module sbs_front
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            strobe_p_n,
  input  logic            strobe_c_n,
  input  logic            adv_n,
  input  logic            ce_a_n,
  input  logic            ce_hi,
  input  logic            ce_b_n,
  input  logic            gwr_n,
  input  logic            bwe_n,
  input  logic [DW/8-1:0] lane_n,
  input  logic            linear_n,
  input  logic            oe_n,
  output logic [DW-1:0]   dq_o,
  output logic            dq_en
);
  localparam int LANE_W = 8;
  localparam int LANES  = DW / LANE_W;

  op_e              op;
  logic             rd_now, wr_now, active, s1_read, data_valid;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    eff_addr, cur_addr, s1_addr;
  logic [DW-1:0]    arr_rd, out_q;

  sbs_decode #(.LANES(LANES)) u_dec (
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
    .ce_a_n(ce_a_n), .ce_hi(ce_hi), .ce_b_n(ce_b_n),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_n(lane_n), .active(active),
    .op(op), .rd_now(rd_now), .wr_now(wr_now), .wr_mask(wr_mask)
  );

  sbs_burst #(.AW(AW)) u_bst (
    .clk(clk), .rst_n(rst_n), .op(op), .addr_in(addr), .linear_n(linear_n),
    .eff_addr(eff_addr), .cur_addr(cur_addr), .active(active)
  );

  sbs_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we_mask(wr_mask), .waddr(eff_addr), .wdata(wdata),
    .raddr(s1_addr), .rdata(arr_rd)
  );

  // stage 1 registers the access, stage 2 holds the read word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_read    <= 1'b0;
      s1_addr    <= '0;
      data_valid <= 1'b0;
      out_q      <= '0;
    end else begin
      s1_read    <= rd_now;
      s1_addr    <= eff_addr;
      data_valid <= s1_read;
      out_q      <= arr_rd;
    end
  end

  assign dq_en = data_valid && !oe_n;
  assign dq_o  = dq_en ? out_q : '0;
endmodule

// File: rtl/sbs_front_chk.sv
module sbs_front_chk
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input op_e           op,
  input logic          rd_now,
  input logic          wr_now,
  input logic          data_valid,
  input logic          dq_en,
  input logic [AW-1:0] cur_addr,
  input logic          active,
  input logic          strobe_p_n,
  input logic          ce_a_n,
  input logic          linear_n
);
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> ##1 data_valid);

  a_r8_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> ##1 !dq_en);

  a_r2_deselect_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> !active);

  a_r4_pstrobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p_n && !ce_a_n) |-> !wr_now);

  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUSP) |=> $stable(cur_addr));

  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CONT && !linear_n) |=>
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));
endmodule

bind sbs_front sbs_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .rd_now(rd_now), .wr_now(wr_now),
  .data_valid(data_valid), .dq_en(dq_en), .cur_addr(cur_addr),
  .active(active), .strobe_p_n(strobe_p_n), .ce_a_n(ce_a_n),
  .linear_n(linear_n)
);

// File: tb/sbs_front_test.sv
module sbs_front_test;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] wd = '0;
  logic sp_n = 1, sc_n = 1, adv_n = 1, ea_n = 0, ehi = 1, eb_n = 0;
  logic gw_n = 1, bw_n = 1, lin_n = 1, oe_n = 0;
  logic [3:0] ln = 4'hf;
  logic [DW-1:0] dq_o;
  logic dq_en;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  sbs_front #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(a), .wdata(wd),
    .strobe_p_n(sp_n), .strobe_c_n(sc_n), .adv_n(adv_n),
    .ce_a_n(ea_n), .ce_hi(ehi), .ce_b_n(eb_n),
    .gwr_n(gw_n), .bwe_n(bw_n), .lane_n(ln), .linear_n(lin_n),
    .oe_n(oe_n), .dq_o(dq_o), .dq_en(dq_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit          valid;
    logic [31:0] data;
    int          due;
    string       req;
  } item_t;
  item_t q[$];

  // reference state
  logic [31:0] mref [64];
  bit          act = 0;
  logic [5:0]  base = '0;
  int          k = 0;

  function automatic logic [1:0] seq(input logic [1:0] s, input int kk, input bit lin);
    int v;
    if (lin) v = (int'(s) + kk) % 4;
    else     v = int'(s) ^ kk;
    return v[1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic step(input logic isp, isc, iadv, iea, iehi, ieb, igw, ibw,
                      input logic [3:0] iln, input logic [5:0] ia,
                      input logic [31:0] id, input logic ioe, input string req);
    int op;
    bit p, wreq, is_wr, is_rd;
    logic [5:0] ea;
    item_t it;
    @(negedge clk); #2;
    sp_n = isp; sc_n = isc; adv_n = iadv; ea_n = iea; ehi = iehi; eb_n = ieb;
    gw_n = igw; bw_n = ibw; ln = iln; a = ia; wd = id; oe_n = ioe;
    p = !isp && !iea;
    if (p)         op = (iehi && !ieb) ? 2 : 1;
    else if (!isc) op = (!iea && iehi && !ieb) ? 2 : 1;
    else if (act)  op = iadv ? 4 : 3;
    else           op = 0;
    if (op == 2) begin act = 1; base = ia; k = 0; end
    if (op == 3) k = (k + 1) % 4;
    if (op == 1) act = 0;
    ea = {base[5:2], seq(base[1:0], k, !lin_n)};
    wreq  = !igw || (!ibw && iln != 4'hf);
    is_wr = (op >= 2) && !p && wreq;
    is_rd = (op >= 2) && !is_wr;
    it.valid = is_rd;
    it.data  = is_rd ? mref[ea] : 32'h0;
    it.due   = cyc + 2;
    it.req   = req;
    if (is_wr)
      for (int i = 0; i < 4; i++)
        if (!igw || !iln[i]) mref[ea][8*i +: 8] = id[8*i +: 8];
    q.push_back(it);
  endtask

  // monitor: compare one scheduled item per cycle
  always @(negedge clk) begin
    #1;
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      bit en_exp;
      it = q.pop_front();
      en_exp = it.valid && !oe_n;
      if (en_exp)
        check(dq_en === 1'b1 && dq_o === it.data, it.req, {dq_en, dq_o[30:0]}, {1'b1, it.data[30:0]});
      else
        check(dq_en === 1'b0, it.req, {31'h0, dq_en}, 32'h0);
    end
  end

  // shorthand: no strobe, enables asserted
  task automatic nx(input logic iadv, igw, ibw, input logic [3:0] iln,
                    input logic [31:0] id, input logic ioe, input string req);
    step(1, 1, iadv, 0, 1, 0, igw, ibw, iln, '0, id, ioe, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 check(dq_en === 1'b0, "R1 reset floats", {31'h0, dq_en}, 32'h0);
    nx(0, 1, 1, 4'hf, 0, 0, "R1 no strobe after reset");
    nx(0, 0, 1, 4'hf, 32'hdead_beef, 0, "R1 no write after reset");

    // R5 global writes, R6 burst 8..11
    step(1, 0, 1, 0, 1, 0, 0, 1, 4'hf, 6'd8, 32'ha0a0_0008, 0, "R5 gw begin");
    nx(0, 0, 1, 4'hf, 32'ha0a0_0009, 0, "R5 gw cont");
    nx(0, 0, 1, 4'hf, 32'ha0a0_000a, 0, "R5 gw cont");
    nx(0, 0, 1, 4'hf, 32'ha0a0_000b, 0, "R5 gw cont");
    // R5 byte writes on all lanes, 16..19
    step(1, 0, 1, 0, 1, 0, 1, 0, 4'h0, 6'd16, 32'hb0b0_0010, 0, "R5 bw begin");
    nx(0, 1, 0, 4'h0, 32'hb0b0_0011, 0, "R5 bw cont");
    nx(0, 1, 0, 4'h0, 32'hb0b0_0012, 0, "R5 bw cont");
    nx(0, 1, 0, 4'h0, 32'hb0b0_0013, 0, "R5 bw cont");

    // R4 + R6 linear: start 9 with global write active
    lin_n = 0;
    step(0, 1, 1, 0, 1, 0, 0, 1, 4'hf, 6'd9, 32'h0, 0, "R4 pstrobe reads");
    nx(0, 1, 1, 4'hf, 0, 0, "R6 linear 2nd");
    nx(0, 1, 1, 4'hf, 0, 0, "R6 linear 3rd");
    nx(0, 1, 1, 4'hf, 0, 0, "R6 linear 4th");
    nx(0, 1, 1, 4'hf, 0, 0, "R6 linear wrap 5th");
    // R6 interleaved: start 17
    step(1, 0, 1, 0, 1, 0, 1, 1, 4'hf, 6'd17, 32'h0, 0, "R6 interleaved begin");
    lin_n = 1;
    nx(0, 1, 1, 4'hf, 0, 0, "R6 interleaved 2nd");
    nx(0, 1, 1, 4'hf, 0, 0, "R6 interleaved 3rd");
    nx(0, 1, 1, 4'hf, 0, 0, "R6 interleaved 4th");

    // R5 lane merge, then read with no write enables
    step(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, 6'd8, 32'h1122_3344, 0, "R5 lane mask write");
    step(1, 0, 1, 0, 1, 0, 1, 1, 4'h0, 6'd8, 32'hffff_ffff, 0, "R5 bwe high reads merged");

    // R7 suspend, read and write
    step(0, 1, 1, 0, 1, 0, 1, 1, 4'hf, 6'd10, 0, 0, "R7 begin at 10");
    nx(1, 1, 1, 4'hf, 0, 0, "R7 suspend read");
    nx(1, 0, 1, 4'hf, 32'hc0de_0010, 0, "R7 suspend write");
    nx(1, 1, 1, 4'hf, 0, 0, "R7 suspend reads new word");

    // R2 enables ignored without strobe
    step(0, 1, 1, 0, 1, 0, 1, 1, 4'hf, 6'd16, 0, 0, "R2 begin at 16");
    step(1, 1, 0, 1, 0, 1, 1, 1, 4'hf, 6'd0, 0, 0, "R2 enables off, no strobe");
    // R3 masked processor strobe continues burst
    step(0, 1, 0, 1, 1, 0, 1, 1, 4'hf, 6'd40, 0, 0, "R3 masked pstrobe");
    // R3 controller strobe with ce_a_n high deselects, then R8 floats
    step(1, 0, 0, 1, 1, 0, 1, 1, 4'hf, 6'd8, 0, 0, "R3 cstrobe deselect");
    nx(0, 1, 1, 4'hf, 0, 0, "R8 idle after deselect");
    // R2 each enable deselects
    step(0, 1, 0, 0, 0, 0, 1, 1, 4'hf, 6'd8, 0, 0, "R2 ce_hi low");
    step(0, 1, 0, 0, 1, 1, 1, 1, 4'hf, 6'd8, 0, 0, "R2 ce_b_n high");
    nx(0, 1, 1, 4'hf, 0, 0, "R2 stays deselected");

    // R9 asynchronous output enable
    step(0, 1, 1, 0, 1, 0, 1, 1, 4'hf, 6'd18, 0, 0, "R9 read for oe");
    step(1, 0, 1, 0, 0, 0, 1, 1, 4'hf, 6'd0, 0, 0, "R8 deselect after read");
    @(negedge clk); #3;
    oe_n = 1; #1;
    check(dq_en === 1'b0, "R9 oe high floats at once", {31'h0, dq_en}, 32'h0);
    oe_n = 0; #1;
    check(dq_en === 1'b1 && dq_o === mref[18], "R9 oe low drives held data", dq_o, mref[18]);

    // R10 dummy reads advance the counter
    step(0, 1, 1, 0, 1, 0, 1, 1, 4'hf, 6'd8, 0, 1, "R10 dummy begin");
    nx(0, 1, 1, 4'hf, 0, 1, "R10 dummy cont");
    nx(0, 1, 1, 4'hf, 0, 1, "R10 visible after dummies");
    nx(0, 1, 1, 4'hf, 0, 0, "R10 visible 4th");

    // drain with deselects
    repeat (3) step(1, 0, 1, 0, 0, 0, 1, 1, 4'hf, 6'd0, 0, 0, "R8 drain deselect");
    repeat (4) @(negedge clk);
    if (q.size() != 0) check(0, "R8 items left", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule